// File: doc/BRIEF.md
# I2C Paged Register Target

This block is an I2C target that gives a bus host byte-wide access to a register file. The file is arranged as several pages of up to 128 registers each. Register 0 is not part of any page. It holds the page selector, and the selector decides which page register addresses 1 to 127 reach. The page selector clears to page 0 on reset.

The block watches the two bus lines through a synchronizer and a short glitch filter. From the filtered lines it detects START, repeated START and STOP conditions and matches its own 7-bit device address. It then accepts register writes and serves register reads. Both kinds of burst auto-increment the register pointer.

SDA is never driven high. The single output `sda_oe` asks the pad to pull the line low. SCL is only observed and never stretched.

Top module: `i2c_paged_regs`

## Requirements
- R1: While reset is held and after it is released, `sda_oe` is 0, the page selector (register 0) reads 0x00, and every paged register reads 0x00.
- R2: After a START, the block acknowledges an address byte whose upper seven bits equal `DEV_ADDR` by holding `sda_oe` high for the ninth clock. For any other address it never acknowledges, and it leaves every following byte unanswered and unstored until the next START.
- R3: In a write (address byte bit 0 = 0), the first data byte loads the register pointer from its low 7 bits, with bit 7 ignored. Each later byte is stored at the pointer, after which the pointer increments. Every data byte is acknowledged.
- R4: Register 0 is the page selector, and it is shared by all pages. Its low bits (bit 0 with two pages) choose the page that addresses 1 to 127 reach. A read of register 0 returns the value last written to it. Writing 0x01 makes page 1 active.
- R5: The same address in different pages names different storage. A write while one page is active leaves the other pages unchanged.
- R6: In a read (address byte bit 0 = 1), the block shifts out the byte at the pointer MSB first. The pointer increments only after a byte that the master acknowledges, and the next byte then comes from the new pointer.
- R7: After a master NACK on a read byte, `sda_oe` stays 0 until the next START. The pointer keeps the address of the byte that was not acknowledged.
- R8: A repeated START is accepted in any state and restarts address matching, so a pointer write can be followed directly by a read.
- R9: A STOP returns the block to idle with `sda_oe` released.
- R10: A pulse on SCL or SDA that is shorter than `FILT_LEN` clock cycles has no effect on what is received or stored.
- R11: `sda_oe` changes only while the filtered SCL is low. The exception is a START or STOP, which releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A write of a byte to the page selector and the advance of the register pointer take effect on the same clock edge. The next byte of the same burst must therefore land in the newly selected page.

The bench provokes this with one burst that starts at register 0 and carries 0x01 followed by a data byte. It then reads address 1 in page 1 and in page 0, and accepts only the result where the data byte appears in page 1 and page 0 stays untouched.

A second coincidence is a master acknowledge and the reload of the shift register for the next read byte. This is judged by reading a three-byte burst back in order.

// File: rtl/i2c_pr_pkg.sv
`timescale 1ns/1ps
package i2c_pr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } pr_state_t;
endpackage

// File: rtl/i2c_pr_glitch.sv
`timescale 1ns/1ps
// Synchronizer plus majority-free glitch filter: the output follows the
// input only after FILT_LEN consecutive equal samples.
module i2c_pr_glitch #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         always_ff @(posedge clk) begin
            if (!rst_n) dout <= 1'b1;
            else        dout <= synced;
         end
      end else begin : g_filt
         logic [FILT_LEN-2:0] hist_q;
         logic [FILT_LEN-1:0] win;
         assign win = {hist_q, synced};
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_q <= '1;
               dout   <= 1'b1;
            end else begin
               hist_q <= win[FILT_LEN-2:0];
               if (&win)       dout <= 1'b1;
               else if (~|win) dout <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_pr_events.sv
`timescale 1ns/1ps
// Bus condition detector working on the filtered lines.
module i2c_pr_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_pr_regfile.sv
`timescale 1ns/1ps
// Page selector at address 0 plus NUM_PAGES banks of paged registers.
module i2c_pr_regfile
   import i2c_pr_pkg::*;
#(
   parameter int NUM_PAGES = 2,
   parameter int ADDR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int REGS   = 1 << ADDR_W;
   localparam int PAGE_W = $clog2(NUM_PAGES);

   logic [BYTE_W-1:0] page_q;
   logic [PAGE_W-1:0] act_page;
   logic [BYTE_W-1:0] page_rd [NUM_PAGES];
   logic              sel_wr;

   assign act_page = page_q[PAGE_W-1:0];
   assign sel_wr   = wr_en && (wr_addr == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      page_q <= '0;
      else if (sel_wr) page_q <= wr_data;
   end

   generate
      for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
         logic [BYTE_W-1:0] cells [REGS];
         logic              bank_wr;
         assign bank_wr = wr_en && (wr_addr != '0) && (act_page == PAGE_W'(p));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < REGS; i++) cells[i] <= '0;
            end else if (bank_wr) begin
               cells[wr_addr] <= wr_data;
            end
         end
         assign page_rd[p] = cells[rd_addr];
      end
   endgenerate

   assign rd_data = (rd_addr == '0) ? page_q : page_rd[act_page];
endmodule

// File: rtl/i2c_paged_regs.sv
`timescale 1ns/1ps
module i2c_paged_regs
   import i2c_pr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int         NUM_PAGES   = 2,
   parameter int         ADDR_W      = 7,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   localparam logic [2:0] LAST_BIT = 3'd7;

   generate
      if (NUM_PAGES < 2 || NUM_PAGES > 256 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
         $error("NUM_PAGES must be a power of two between 2 and 256");
      end
      if (ADDR_W < 1 || ADDR_W > 7) begin : g_bad_addr
         $error("ADDR_W must lie between 1 and 7");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   logic scl_f, sda_f;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_pr_glitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_flt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
   i2c_pr_glitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_flt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   i2c_pr_events u_evt (
      .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   pr_state_t         state_q;
   logic [2:0]        bit_cnt;
   logic              got_q;
   logic              first_q;
   logic              rd_q;
   logic              mack_q;
   logic              sda_oe_q;
   logic [BYTE_W-1:0] rx_sr;
   logic [BYTE_W-1:0] tx_sr;
   logic [ADDR_W-1:0] ptr_q;
   logic [BYTE_W-1:0] rd_data;
   logic              wr_en;

   assign wr_en  = (state_q == ST_WDATA) && scl_fall && got_q && !first_q;
   assign sda_oe = sda_oe_q;

   i2c_pr_regfile #(.NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(ptr_q), .wr_data(rx_sr),
      .rd_addr(ptr_q), .rd_data(rd_data));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bit_cnt  <= '0;
         got_q    <= 1'b0;
         first_q  <= 1'b0;
         rd_q     <= 1'b0;
         mack_q   <= 1'b0;
         sda_oe_q <= 1'b0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         ptr_q    <= '0;
      end else if (start_det) begin
         state_q  <= ST_ADDR;
         bit_cnt  <= '0;
         got_q    <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (stop_det) begin
         state_q  <= ST_IDLE;
         got_q    <= 1'b0;
         sda_oe_q <= 1'b0;
      end else begin
         case (state_q)
            ST_ADDR, ST_WDATA: begin
               if (scl_rise) begin
                  rx_sr   <= {rx_sr[BYTE_W-2:0], sda_f};
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == LAST_BIT) got_q <= 1'b1;
               end else if (scl_fall && got_q) begin
                  got_q <= 1'b0;
                  if (state_q == ST_ADDR) begin
                     if (rx_sr[BYTE_W-1:1] == DEV_ADDR) begin
                        rd_q     <= rx_sr[0];
                        sda_oe_q <= 1'b1;
                        state_q  <= ST_ADDR_ACK;
                     end else begin
                        state_q  <= ST_IGNORE;
                     end
                  end else begin
                     if (first_q) begin
                        ptr_q   <= rx_sr[ADDR_W-1:0];
                        first_q <= 1'b0;
                     end else begin
                        ptr_q   <= ptr_q + ADDR_W'(1);
                     end
                     sda_oe_q <= 1'b1;
                     state_q  <= ST_WACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  got_q   <= 1'b0;
                  if (rd_q) begin
                     tx_sr    <= rd_data;
                     sda_oe_q <= ~rd_data[BYTE_W-1];
                     state_q  <= ST_RDATA;
                  end else begin
                     first_q  <= 1'b1;
                     sda_oe_q <= 1'b0;
                     state_q  <= ST_WDATA;
                  end
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  bit_cnt  <= '0;
                  sda_oe_q <= 1'b0;
                  state_q  <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == LAST_BIT) got_q <= 1'b1;
               end else if (scl_fall) begin
                  if (got_q) begin
                     got_q    <= 1'b0;
                     sda_oe_q <= 1'b0;
                     state_q  <= ST_RACK;
                  end else begin
                     tx_sr    <= {tx_sr[BYTE_W-2:0], 1'b0};
                     sda_oe_q <= ~tx_sr[BYTE_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_f;
                  if (!sda_f) ptr_q <= ptr_q + ADDR_W'(1);
               end else if (scl_fall) begin
                  if (mack_q) begin
                     bit_cnt  <= '0;
                     tx_sr    <= rd_data;
                     sda_oe_q <= ~rd_data[BYTE_W-1];
                     state_q  <= ST_RDATA;
                  end else begin
                     sda_oe_q <= 1'b0;
                     state_q  <= ST_IGNORE;
                  end
               end
            end
            default: begin
               sda_oe_q <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/i2c_paged_regs_chk.sv
`timescale 1ns/1ps
module i2c_paged_regs_chk
   import i2c_pr_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      sda_oe,
   input logic      scl_f,
   input logic      start_det,
   input logic      stop_det,
   input pr_state_t state,
   input logic      wr_en
);
   assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

   assert_ignore_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe);

   assert_drive_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state inside {ST_ADDR_ACK, ST_WACK, ST_RDATA}));

   assert_sda_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && !start_det && !stop_det) |=> $stable(sda_oe));

   assert_wr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (state == ST_WACK && sda_oe));
endmodule

bind i2c_paged_regs i2c_paged_regs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f),
   .start_det(start_det), .stop_det(stop_det), .state(state_q), .wr_en(wr_en));

// File: tb/i2c_paged_regs_test.sv
`timescale 1ns/1ps
module i2c_paged_regs_test;
   localparam logic [6:0] DEV = 7'h2C;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;
   int   checks = 0;
   int   failures = 0;
   int   hold_err = 0;
   bit   done = 1'b0;

   assign sda_bus = sda_m & ~sda_oe;
   always #2.5 clk = ~clk;

   i2c_paged_regs #(.DEV_ADDR(DEV)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe));

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(2*Q);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = ~sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   // Same as send_byte, with a short SCL pulse in every low phase and a
   // short SDA dip in every high phase that carries a one.
   task automatic send_byte_glitch(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(4);
         scl_m = 1'b1; tick(1);
         scl_m = 1'b0; tick(Q - 5);
         scl_m = 1'b1; tick(Q);
         if (b[i]) begin
            sda_m = 1'b0; tick(1);
            sda_m = 1'b1; tick(Q - 1);
         end else begin
            tick(Q);
         end
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = ~sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit mack);
      logic first_s;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; tick(Q);
         scl_m = 1'b1; tick(2);
         first_s = sda_bus; tick(Q - 2);
         b[i] = sda_bus; tick(Q - 1);
         if (sda_bus !== first_s || sda_bus !== b[i]) hold_err++;
         tick(1);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = mack ? 1'b0 : 1'b1; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic write_regs(input logic [6:0] dev, input logic [7:0] ra, input int n,
                             input logic [23:0] data, output bit all_ack);
      bit a;
      all_ack = 1'b1;
      bus_start();
      send_byte({dev, 1'b0}, a); all_ack &= a;
      send_byte(ra, a);          all_ack &= a;
      for (int k = 0; k < n; k++) begin
         send_byte(data[8*k +: 8], a); all_ack &= a;
      end
      bus_stop();
   endtask

   task automatic read_regs(input logic [7:0] ra, input int n,
                            output logic [23:0] data, output bit all_ack);
      bit a;
      logic [7:0] b;
      all_ack = 1'b1;
      data = '0;
      bus_start();
      send_byte({DEV, 1'b0}, a); all_ack &= a;
      send_byte(ra, a);          all_ack &= a;
      bus_rstart();
      send_byte({DEV, 1'b1}, a); all_ack &= a;
      for (int k = 0; k < n; k++) begin
         recv_byte(b, k != n - 1);
         data[8*k +: 8] = b;
      end
      bus_stop();
   endtask

   task automatic t_reset();
      logic [23:0] d;
      bit ok;
      check_eq("R1 sda_oe released after reset", {31'd0, sda_oe}, 32'd0);
      read_regs(8'h00, 2, d, ok);
      check_eq("R1 selector and page0 reg1 clear", {8'd0, d}, 32'h0000_0000);
      check_eq("R8 acks with repeated START", {31'd0, ok}, 32'd1);
   endtask

   task automatic t_write_read();
      logic [23:0] d;
      bit ok;
      write_regs(DEV, 8'h03, 3, 24'hC3B2A1, ok);
      check_eq("R3 burst write acked", {31'd0, ok}, 32'd1);
      read_regs(8'h03, 3, d, ok);
      check_eq("R6 burst read in order", {8'd0, d}, 32'h00C3B2A1);
      check_eq("R8 write-then-read acks", {31'd0, ok}, 32'd1);
   endtask

   task automatic t_nack();
      bit a;
      logic [7:0] b;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h03, a);
      bus_rstart();
      send_byte({DEV, 1'b1}, a);
      hold_err = 0;
      recv_byte(b, 1'b1);
      check_eq("R6 first read byte", {24'd0, b}, 32'hA1);
      recv_byte(b, 1'b0);
      check_eq("R6 second read byte", {24'd0, b}, 32'hB2);
      check_eq("R11 SDA steady while SCL high", hold_err, 32'd0);
      check_eq("R7 released after NACK", {31'd0, sda_oe}, 32'd0);
      recv_byte(b, 1'b0);
      check_eq("R7 nothing driven after NACK", {24'd0, b}, 32'hFF);
      bus_stop();
      check_eq("R9 released after STOP", {31'd0, sda_oe}, 32'd0);
      bus_start();
      send_byte({DEV, 1'b1}, a);
      recv_byte(b, 1'b0);
      bus_stop();
      check_eq("R7 pointer held on NACKed byte", {24'd0, b}, 32'hB2);
   endtask

   task automatic t_wrong_dev();
      logic [23:0] d;
      bit a;
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b0}, a);
      check_eq("R2 foreign address not acked", {31'd0, a}, 32'd0);
      send_byte(8'h03, a);
      check_eq("R2 bytes ignored after mismatch", {31'd0, a}, 32'd0);
      send_byte(8'h55, a);
      bus_stop();
      read_regs(8'h03, 1, d, a);
      check_eq("R2 register untouched by foreign write", {8'd0, d}, 32'hA1);
   endtask

   task automatic t_page();
      logic [23:0] d;
      bit ok;
      write_regs(DEV, 8'h00, 2, 24'h007701, ok);
      check_eq("R4 selector write acked", {31'd0, ok}, 32'd1);
      read_regs(8'h00, 2, d, ok);
      check_eq("R4 selector=01 and page1 reg1 took next byte", {8'd0, d}, 32'h7701);
      write_regs(DEV, 8'h00, 1, 24'h000000, ok);
      read_regs(8'h00, 2, d, ok);
      check_eq("R5 page0 reg1 unaffected by page1 write", {8'd0, d}, 32'h0000);
      read_regs(8'h03, 1, d, ok);
      check_eq("R5 page0 data kept across switch", {8'd0, d}, 32'hA1);
   endtask

   task automatic t_addr_msb();
      logic [23:0] d;
      bit ok;
      write_regs(DEV, 8'h85, 1, 24'h000099, ok);
      read_regs(8'h05, 1, d, ok);
      check_eq("R3 address bit 7 ignored", {8'd0, d}, 32'h99);
   endtask

   task automatic t_glitch();
      logic [23:0] d;
      bit a;
      bit all_ok;
      all_ok = 1'b1;
      bus_start();
      send_byte({DEV, 1'b0}, a);       all_ok &= a;
      send_byte(8'h06, a);             all_ok &= a;
      send_byte_glitch(8'h3C, a);      all_ok &= a;
      bus_stop();
      check_eq("R10 acks under glitches", {31'd0, all_ok}, 32'd1);
      read_regs(8'h06, 1, d, a);
      check_eq("R10 data intact under glitches", {8'd0, d}, 32'h3C);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      tick(8);
      check_eq("R1 sda_oe low during reset", {31'd0, sda_oe}, 32'd0);
      rst_n = 1'b1;
      tick(12);
      t_reset();
      t_write_read();
      t_nack();
      t_wrong_dev();
      t_page();
      t_addr_msb();
      t_glitch();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule